// File: doc/BRIEF.md
# Masked Atomic GPIO Port

This block is a general-purpose I/O port with a parameterizable width (32 bits by default). It sits on a simple two-phase register bus in the style of APB. It holds an output value vector and an output-enable vector. Software changes either vector in one of four ways: by writing ones to a set register, a clear register or a toggle register, or by writing the register directly. These updates are atomic, so no read-modify-write sequence is needed to change a single pin.

Each vector has its own protect mask. A protected bit cannot be changed by any of the four update forms, including a direct write. A read-only register returns the pad levels after they pass through a multi-flop synchronizer.

The bus address holds two groups of registers. The value group starts at offset 0x000 and the enable group starts at offset 0x020. Address bits [1:0] are not decoded. Any address with a bit set at position 6 or above is treated as unmapped.

Top module: `gpio_atomic_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, `gpio_out`, `gpio_oe` and both mask registers are all zero. The mask registers are at offsets 0x00C and 0x02C.
- R2: A write to offset 0x000 sets to 1 every `gpio_out` bit that has a 1 in the write data and is not protected. Bits written 0 keep their value.
- R3: A write to offset 0x004 clears to 0 every `gpio_out` bit that has a 1 in the write data and is not protected. Bits written 0 keep their value.
- R4: A write to offset 0x008 inverts every `gpio_out` bit that has a 1 in the write data and is not protected. Bits written 0 keep their value.
- R5: A write to offset 0x010 copies the write data into the unprotected bits of `gpio_out`. A read of 0x010 returns the current `gpio_out`.
- R6: The value mask at offset 0x00C can be read and written. A 1 in a mask bit freezes that `gpio_out` bit against offsets 0x000, 0x004, 0x008 and 0x010.
- R7: Offsets 0x020 (set), 0x024 (clear), 0x028 (toggle), 0x02C (mask) and 0x030 (direct write and read) act on `gpio_oe` in the same way, under their own mask. A 1 in `gpio_oe` means the pin drives (output).
- R8: A read of offset 0x014 returns `gpio_in` delayed by two clock edges. A change applied before edge k is visible after edge k+1 and is not visible after edge k alone.
- R9: Offsets 0x000, 0x004, 0x008, 0x020, 0x024 and 0x028 read as zero. The reserved offsets (0x018, 0x01C and 0x034 to 0x03C) also read as zero. Writes to 0x014 and to the reserved offsets change neither output vector.
- R10: A write takes effect only in the access cycle, where `bus_sel`, `bus_en` and `bus_wr` are all high. The outputs change on the clock edge that ends that cycle. A setup cycle or a read access leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_en | input | 1 | Access phase (second cycle of a transfer) |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when not selected |
| gpio_in | input | DATA_W | Raw pad levels |
| gpio_out | output | DATA_W | Output value vector |
| gpio_oe | output | DATA_W | Output enable vector (1 = drive) |

## Verification
The update forms are run from a table. It first applies set, clear, toggle and direct writes with no mask, so that each operation's effect on bits written 1 and on bits written 0 can be told apart. It then repeats them under a half-word mask, which separates protected bits from free bits and shows that a direct write respects the mask. Enable-group rows run under a different mask while `gpio_out` is checked for no change, which shows that the two groups are independent. Further rows write the pin and reserved offsets, and directed tests cover synchronizer latency, setup-only and read cycles, and reset in the middle of a run.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   // Word slot within a register group, taken from bus_addr[4:2]
   localparam logic [2:0] SLOT_SET = 3'd0;
   localparam logic [2:0] SLOT_CLR = 3'd1;
   localparam logic [2:0] SLOT_TOG = 3'd2;
   localparam logic [2:0] SLOT_MSK = 3'd3;
   localparam logic [2:0] SLOT_VAL = 3'd4;
   localparam logic [2:0] SLOT_PIN = 3'd5;

   // Number of register groups: value group and enable group
   localparam int GROUPS = 2;

   // One-hot write strobes for one register group
   typedef struct packed {
      logic set;
      logic clr;
      logic tog;
      logic msk;
      logic val;
   } bank_wr_t;

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
   import gpio_atomic_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output bank_wr_t [GROUPS-1:0] wr_strb,
   output logic              rd_hit,
   output logic              rd_grp,
   output logic [2:0]        rd_slot
);

   logic mapped;
   logic wr_go;

   always_comb begin
      mapped  = (bus_addr >> 6) == '0;
      rd_grp  = bus_addr[5];
      rd_slot = bus_addr[4:2];
      rd_hit  = bus_sel && mapped;
      wr_go   = bus_sel && bus_en && bus_wr && mapped;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_strb
      always_comb begin
         wr_strb[g] = '0;
         if (wr_go && (rd_grp == g[0])) begin
            unique case (rd_slot)
               SLOT_SET: wr_strb[g].set = 1'b1;
               SLOT_CLR: wr_strb[g].clr = 1'b1;
               SLOT_TOG: wr_strb[g].tog = 1'b1;
               SLOT_MSK: wr_strb[g].msk = 1'b1;
               SLOT_VAL: wr_strb[g].val = 1'b1;
               default:  ;
            endcase
         end
      end
   end

endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
   import gpio_atomic_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_wr_t          strb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] mask
);

   logic [DATA_W-1:0] free_bits;
   logic [DATA_W-1:0] value_nxt;

   // Only unprotected bits of the write data may act
   always_comb begin
      free_bits = wdata & ~mask;
      value_nxt = value;
      if (strb.set) value_nxt = value | free_bits;
      if (strb.clr) value_nxt = value & ~free_bits;
      if (strb.tog) value_nxt = value ^ free_bits;
      if (strb.val) value_nxt = (value & mask) | free_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         mask  <= '0;
      end else begin
         value <= value_nxt;
         if (strb.msk) mask <= wdata;
      end
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int DATA_W = 32,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   logic [STAGES-1:0][DATA_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port
   import gpio_atomic_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] gpio_in,
   output logic [DATA_W-1:0] gpio_out,
   output logic [DATA_W-1:0] gpio_oe
);

   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W must be 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   bank_wr_t [GROUPS-1:0] wr_strb;
   logic                  rd_hit;
   logic                  rd_grp;
   logic [2:0]            rd_slot;
   logic [DATA_W-1:0]     bank_val [GROUPS];
   logic [DATA_W-1:0]     bank_msk [GROUPS];
   logic [DATA_W-1:0]     pin_sync;

   gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_en  (bus_en),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .wr_strb (wr_strb),
      .rd_hit  (rd_hit),
      .rd_grp  (rd_grp),
      .rd_slot (rd_slot)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_bank
      gpio_reg_bank #(.DATA_W(DATA_W)) u_bank (
         .clk  (clk),
         .rst_n(rst_n),
         .strb (wr_strb[g]),
         .wdata(bus_wdata),
         .value(bank_val[g]),
         .mask (bank_msk[g])
      );
   end

   gpio_in_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (gpio_in),
      .dout (pin_sync)
   );

   // Read path: write-only and reserved slots return zero
   always_comb begin
      bus_rdata = '0;
      if (rd_hit) begin
         unique case (rd_slot)
            SLOT_MSK: bus_rdata = bank_msk[rd_grp];
            SLOT_VAL: bus_rdata = bank_val[rd_grp];
            SLOT_PIN: bus_rdata = rd_grp ? '0 : pin_sync;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign gpio_out = bank_val[0];
   assign gpio_oe  = bank_val[1];

endmodule

// File: rtl/gpio_atomic_chk.sv
module gpio_atomic_chk #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_en,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] gpio_in,
   input logic [DATA_W-1:0] gpio_out,
   input logic [DATA_W-1:0] gpio_oe,
   input logic [DATA_W-1:0] dat_mask,
   input logic [DATA_W-1:0] dir_mask
);

   logic       mapped, wr_acc, grp;
   logic [2:0] slot;
   logic [1:0] since_rst;

   assign mapped = (bus_addr >> 6) == '0;
   assign wr_acc = bus_sel && bus_en && bus_wr && mapped;
   assign grp    = bus_addr[5];
   assign slot   = bus_addr[4:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   a_r2_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !grp && slot == 3'd0) |=>
      ((~gpio_out & $past(bus_wdata & ~dat_mask)) == '0));

   a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !grp && slot == 3'd1) |=>
      ((gpio_out & $past(bus_wdata & ~dat_mask)) == '0));

   a_r4_tog_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && !grp && slot == 3'd2) |=>
      ((gpio_out ^ $past(gpio_out)) == $past(bus_wdata & ~dat_mask)));

   a_r6_dat_mask_protects: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst != 2'd0 |->
      (((gpio_out ^ $past(gpio_out)) & $past(dat_mask)) == '0));

   a_r7_dir_mask_protects: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst != 2'd0 |->
      (((gpio_oe ^ $past(gpio_oe)) & $past(dir_mask)) == '0));

   a_r10_out_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && !grp && slot != 3'd3 && slot <= 3'd4) |=> $stable(gpio_out));

   a_r10_oe_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && grp && slot != 3'd3 && slot <= 3'd4) |=> $stable(gpio_oe));

   a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && mapped && slot <= 3'd2) |-> bus_rdata == '0);

   if (SYNC_STAGES == 2) begin : g_sync_chk
      a_r8_pin_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && bus_sel && mapped && !grp && slot == 3'd5) |->
         bus_rdata == $past(gpio_in, 2));
   end

endmodule

bind gpio_atomic_port gpio_atomic_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_en   (bus_en),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .gpio_in  (gpio_in),
   .gpio_out (gpio_out),
   .gpio_oe  (gpio_oe),
   .dat_mask (bank_msk[0]),
   .dir_mask (bank_msk[1])
);

// File: tb/sim_gpio_atomic_port.sv
module sim_gpio_atomic_port;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 19;

   typedef struct packed {
      logic [11:0] a;
      logic [31:0] w;
      logic [31:0] eo;
      logic [31:0] ee;
   } vec_t;

   // address, write data, expected gpio_out, expected gpio_oe
   localparam vec_t VEC [NV] = '{
      '{12'h010, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000},
      '{12'h000, 32'h0000_000F, 32'h0000_00FF, 32'h0000_0000},
      '{12'h004, 32'h0000_0081, 32'h0000_007E, 32'h0000_0000},
      '{12'h008, 32'hFFFF_0000, 32'hFFFF_007E, 32'h0000_0000},
      '{12'h00C, 32'h0000_FFFF, 32'hFFFF_007E, 32'h0000_0000},
      '{12'h010, 32'h1234_5678, 32'h1234_007E, 32'h0000_0000},
      '{12'h004, 32'hFFFF_FFFF, 32'h0000_007E, 32'h0000_0000},
      '{12'h008, 32'hFFFF_FFFF, 32'hFFFF_007E, 32'h0000_0000},
      '{12'h000, 32'hFFFF_FFFF, 32'hFFFF_007E, 32'h0000_0000},
      '{12'h020, 32'h0000_00FF, 32'hFFFF_007E, 32'h0000_00FF},
      '{12'h02C, 32'h0000_000F, 32'hFFFF_007E, 32'h0000_00FF},
      '{12'h024, 32'hFFFF_FFFF, 32'hFFFF_007E, 32'h0000_000F},
      '{12'h028, 32'h0000_0030, 32'hFFFF_007E, 32'h0000_003F},
      '{12'h030, 32'hA000_0000, 32'hFFFF_007E, 32'hA000_000F},
      '{12'h014, 32'hFFFF_FFFF, 32'hFFFF_007E, 32'hA000_000F},
      '{12'h018, 32'h0000_0000, 32'hFFFF_007E, 32'hA000_000F},
      '{12'h034, 32'hFFFF_FFFF, 32'hFFFF_007E, 32'hA000_000F},
      '{12'h00C, 32'h0000_0000, 32'hFFFF_007E, 32'hA000_000F},
      '{12'h010, 32'h0000_0000, 32'h0000_0000, 32'hA000_000F}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] gpio_in = '0;
   logic [31:0] gpio_out, gpio_oe;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_atomic_port u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Two-phase write; returns at the falling edge after the access edge
   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   // Combinational read in the current low phase, no clock edge used
   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0; bus_en = 1'b0;
   endtask

   function automatic string tag_of(input logic [11:0] a);
      case (a)
         12'h000: return "R2";
         12'h004: return "R3";
         12'h008: return "R4";
         12'h00C: return "R6";
         12'h010: return "R5";
         12'h020, 12'h024, 12'h028, 12'h02C, 12'h030: return "R7";
         default: return "R9";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 out in reset", gpio_out, 32'h0);
      check("R1 oe in reset", gpio_oe, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out after reset", gpio_out, 32'h0);
      check("R1 oe after reset", gpio_oe, 32'h0);
      bus_read(12'h00C, rd); check("R1 dat mask", rd, 32'h0);
      bus_read(12'h02C, rd); check("R1 dir mask", rd, 32'h0);

      for (int i = 0; i < NV; i++) begin
         bus_write(VEC[i].a, VEC[i].w);
         check({tag_of(VEC[i].a), " row out"}, gpio_out, VEC[i].eo);
         check({tag_of(VEC[i].a), " row oe"}, gpio_oe, VEC[i].ee);
      end

      // readbacks
      bus_read(12'h030, rd); check("R7 dir read", rd, 32'hA000_000F);
      bus_read(12'h02C, rd); check("R7 dir mask read", rd, 32'h0000_000F);
      bus_read(12'h00C, rd); check("R6 dat mask read", rd, 32'h0);
      bus_write(12'h000, 32'h0000_1234);
      check("R2 set after mask", gpio_out, 32'h0000_1234);
      bus_read(12'h010, rd); check("R5 data read", rd, 32'h0000_1234);
      bus_read(12'h000, rd); check("R9 set reads 0", rd, 32'h0);
      bus_read(12'h004, rd); check("R9 clr reads 0", rd, 32'h0);
      bus_read(12'h008, rd); check("R9 tog reads 0", rd, 32'h0);
      bus_read(12'h020, rd); check("R9 dir set reads 0", rd, 32'h0);
      bus_read(12'h028, rd); check("R9 dir tog reads 0", rd, 32'h0);
      bus_read(12'h018, rd); check("R9 reserved reads 0", rd, 32'h0);
      bus_read(12'h03C, rd); check("R9 reserved hi reads 0", rd, 32'h0);

      // R10: setup phase only, then a read access, on the set register
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0;
      bus_addr = 12'h000; bus_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R10 setup only", gpio_out, 32'h0000_1234);
      bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 12'h020;
      @(negedge clk);
      bus_sel = 1'b0; bus_en = 1'b0;
      check("R10 read access out", gpio_out, 32'h0000_1234);
      check("R10 read access oe", gpio_oe, 32'hA000_000F);

      // R8: synchronizer latency
      @(negedge clk);
      gpio_in = 32'h5A5A_C3C3;
      @(negedge clk);
      bus_read(12'h014, rd); check("R8 pin after one edge", rd, 32'h0);
      @(negedge clk);
      bus_read(12'h014, rd); check("R8 pin after two edges", rd, 32'h5A5A_C3C3);
      gpio_in = 32'h0000_FFFF;
      repeat (2) @(negedge clk);
      bus_read(12'h014, rd); check("R8 pin second value", rd, 32'h0000_FFFF);

      // R1: reset in the middle of a run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset out", gpio_out, 32'h0);
      check("R1 mid reset oe", gpio_oe, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(12'h02C, rd); check("R1 mid reset dir mask", rd, 32'h0);

      summary();
   end

endmodule